// File: doc/BRIEF.md
# Half-Band Rate-Changing Filter Core

This block is a seven-tap symmetric half-band FIR filter that runs from a single clock. It can double the sample rate, halve it, or keep it unchanged. Two active-low select pins choose the rate mode. A 12-bit two's-complement sample enters on each rising edge.

When interpolating, the core accepts a sample only on alternate clocks and feeds a zero into the filter on the clocks in between. When decimating, every sample enters the filter, but a result is published only on alternate clocks. In equal-rate mode every clock carries one sample in and one result out.

A registered phase toggle decides which clocks are the active slots in the two rate-changing modes. The toggle runs freely after reset. The sync input re-anchors it at any time: the sync level is high on one clock and low on the next. The core delivers an exact accumulator result with a valid flag. It never saturates or wraps, because limiting and output formatting belong to a separate output stage.

Top module: `hb_rate_filter`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves `acc_valid` at 0 and `acc_out` at 0.
- R2: The select pins decode as follows. `up_sel_n`=0 with `down_sel_n`=1 selects interpolation. `up_sel_n`=1 with `down_sel_n`=0 selects decimation. Equal pin levels select equal rate when parameter `UNITY_BOTH_LOW` is 0.
- R3: In equal rate, every clock's `din` enters the filter. The result for the sample presented in cycle c is visible during cycle c+2 with `acc_valid`=1. That result is -s[c] + 9·s[c-2] + 16·s[c-3] + 9·s[c-4] - s[c-6], where s[k] is the value fed in cycle k and is 0 before the first cycle after reset.
- R4: In interpolation, s[c] equals `din` in slot cycles and 0 in the other cycles. `acc_valid` is 1 for every result.
- R5: In decimation, s[c] equals `din` in every cycle. `acc_valid` is 1 during cycle c+2 only when cycle c was a slot. Otherwise `acc_out` keeps its previous value.
- R6: The first cycle after reset is a slot, and slots then alternate. If `sync_in` is high in cycle N-1 and low in cycle N, then cycle N is a slot and slots alternate from there.
- R7: In equal rate, `sync_in` has no effect: the results and `acc_valid` are the same for any sync waveform.
- R8: With `UNITY_BOTH_LOW`=1, both pins low select interpolation with every result doubled. Both pins high still select equal rate.
- R9: `acc_out` is the exact integer sum, with no wrap, for full-scale inputs of +2047 and -2048. This includes the doubled case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| up_sel_n | input | 1 | Active-low select for interpolation |
| down_sel_n | input | 1 | Active-low select for decimation |
| sync_in | input | 1 | Phase alignment strobe (high then low marks a slot) |
| din | input | DIN_W (12) | Two's-complement input sample |
| acc_out | output | ACC_W (22) | Exact signed filter sum |
| acc_valid | output | 1 | High when `acc_out` carries a new result |

## Verification
The bench sweeps every pin code, against both variants of the both-low behaviour. It uses an impulse, random data and full-scale data. It also applies sync held low, sync toggling at half rate and a single mid-stream re-anchor.

The impulse run exposes a wrong kernel, a mis-ordered tap or an extra register, because the -1/9/16/9/-1 response would land at the wrong cycles. The re-anchor runs catch a phase toggle that ignores the high-then-low pattern, or that triggers on a plain low level, because zeros or valid flags would land in the wrong slots.

Full-scale data catches an accumulator that is too narrow. Random sync in equal rate catches a design that lets the strobe gate equal-rate results.

// File: rtl/hb_rate_pkg.sv
package hb_rate_pkg;

    localparam int DIN_W    = 12;
    localparam int COEF_W   = 6;
    localparam int NTAPS    = 7;
    localparam int CENTRE   = (NTAPS - 1) / 2;
    localparam int NPAIR    = (NTAPS + 1) / 4;
    localparam int CENTRE_C = 16;
    localparam int SUM_GROW = 3;

    typedef enum logic [1:0] {
        RATE_EQUAL = 2'b00,
        RATE_UP    = 2'b01,
        RATE_DOWN  = 2'b10
    } rate_e;

    typedef struct packed {
        rate_e mode;
        logic  gain2;
        logic  tag;
        logic  run;
    } stage_ctl_t;

    // Non-zero off-centre coefficient for pair p (offset 2p+1 from centre)
    function automatic int pair_coef(input int p);
        return (p == 0) ? 9 : -1;
    endfunction

    function automatic rate_e decode_rate(input logic up_n, input logic dn_n,
                                          input logic unity_both_low);
        if (!up_n && dn_n)
            return RATE_UP;
        if (up_n && !dn_n)
            return RATE_DOWN;
        if (!up_n && !dn_n && unity_both_low)
            return RATE_UP;
        return RATE_EQUAL;
    endfunction

endpackage

// File: rtl/hb_phase_track.sv
module hb_phase_track (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic slot_now
);
    logic sync_q;
    logic slot_q;
    logic anchor;

    assign anchor   = sync_q && !sync_in;
    assign slot_now = anchor ? 1'b1 : !slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            slot_q <= 1'b0;
        end else begin
            sync_q <= sync_in;
            slot_q <= slot_now;
        end
    end

    // R6
    sync_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sync_in) && !sync_in && !$past(rst)) |-> slot_now);

    // R6
    slot_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_now && !sync_in) |=> !slot_now);

endmodule

// File: rtl/hb_tap_line.sv
module hb_tap_line #(
    parameter int DW = 12,
    parameter int NT = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DW-1:0]          din,
    input  logic                   stuff_zero,
    output logic [NT-1:0][DW-1:0]  taps
);
    always_ff @(posedge clk) begin
        if (rst)
            taps[0] <= '0;
        else
            taps[0] <= stuff_zero ? '0 : din;
    end

    for (genvar k = 1; k < NT; k++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst)
                taps[k] <= '0;
            else
                taps[k] <= taps[k-1];
        end
    end

endmodule

// File: rtl/hb_symm_mac.sv
module hb_symm_mac
    import hb_rate_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 22,
    parameter int NT = 7
) (
    input  logic [NT-1:0][DW-1:0] taps,
    output logic signed [AW-1:0]  sum
);
    localparam int CTR = (NT - 1) / 2;
    localparam int NP  = (NT + 1) / 4;

    function automatic logic signed [AW-1:0] widen(input logic [DW-1:0] x);
        return {{(AW-DW){x[DW-1]}}, x};
    endfunction

    logic signed [AW-1:0] prod [NP];
    logic signed [AW-1:0] centre_prod;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam int OFS = 2 * p + 1;
        logic signed [AW-1:0] pre;
        assign pre     = widen(taps[CTR-OFS]) + widen(taps[CTR+OFS]);
        assign prod[p] = pre * AW'(pair_coef(p));
    end

    assign centre_prod = widen(taps[CTR]) * AW'(CENTRE_C);

    always_comb begin
        sum = centre_prod;
        for (int p = 0; p < NP; p++)
            sum = sum + prod[p];
    end

endmodule

// File: rtl/hb_rate_filter.sv
module hb_rate_filter
    import hb_rate_pkg::*;
#(
    parameter int DIN_W          = hb_rate_pkg::DIN_W,
    parameter int ACC_W          = DIN_W + hb_rate_pkg::COEF_W + hb_rate_pkg::SUM_GROW + 1,
    parameter bit UNITY_BOTH_LOW = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up_sel_n,
    input  logic                    down_sel_n,
    input  logic                    sync_in,
    input  logic [DIN_W-1:0]        din,
    output logic signed [ACC_W-1:0] acc_out,
    output logic                    acc_valid
);
    localparam int NT = hb_rate_pkg::NTAPS;

    rate_e                     mode_c;
    logic                      gain2_c;
    logic                      slot_now;
    logic                      stuff_zero;
    stage_ctl_t                ctl1;
    logic [NT-1:0][DIN_W-1:0]  taps;
    logic signed [ACC_W-1:0]   mac_sum;
    logic                      publish;

    assign mode_c     = decode_rate(up_sel_n, down_sel_n, UNITY_BOTH_LOW);
    assign gain2_c    = UNITY_BOTH_LOW && !up_sel_n && !down_sel_n;
    assign stuff_zero = (mode_c == RATE_UP) && !slot_now;

    hb_phase_track u_phase (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .slot_now (slot_now)
    );

    hb_tap_line #(.DW(DIN_W), .NT(NT)) u_line (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .stuff_zero (stuff_zero),
        .taps       (taps)
    );

    hb_symm_mac #(.DW(DIN_W), .AW(ACC_W), .NT(NT)) u_mac (
        .taps (taps),
        .sum  (mac_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1 <= '0;
        end else begin
            ctl1.mode  <= mode_c;
            ctl1.gain2 <= gain2_c;
            ctl1.tag   <= (mode_c == RATE_DOWN) ? slot_now : 1'b1;
            ctl1.run   <= 1'b1;
        end
    end

    assign publish = ctl1.run && ctl1.tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out   <= '0;
            acc_valid <= 1'b0;
        end else begin
            acc_valid <= publish;
            if (publish)
                acc_out <= ctl1.gain2 ? (mac_sum <<< 1) : mac_sum;
        end
    end

    // R4
    stuff_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stuff_zero |=> (taps[0] == '0));

    // R3
    every_cycle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl1.run && ctl1.mode != RATE_DOWN) |=> acc_valid);

    // R5
    decim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !$past(rst)) |-> $stable(acc_out));

endmodule

// File: tb/hb_rate_filter_tb.sv
`timescale 1ns/1ps
module hb_rate_filter_tb;
    localparam int DW   = 12;
    localparam int AW   = 22;
    localparam int MAXC = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_n = 1'b1;
    logic dn_n = 1'b1;
    logic sync_in = 1'b0;
    logic [DW-1:0] din = '0;
    logic signed [AW-1:0] acc_a, acc_b;
    logic val_a, val_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int s_h   [2][MAXC];
    bit tag_h [2][MAXC];
    int gain  [2];
    int hold  [2];

    always #4 clk = ~clk;

    hb_rate_filter #(.UNITY_BOTH_LOW(1'b0)) u_dut (
        .clk(clk), .rst(rst), .up_sel_n(up_n), .down_sel_n(dn_n),
        .sync_in(sync_in), .din(din), .acc_out(acc_a), .acc_valid(val_a));

    hb_rate_filter #(.UNITY_BOTH_LOW(1'b1)) u_dut_u (
        .clk(clk), .rst(rst), .up_sel_n(up_n), .down_sel_n(dn_n),
        .sync_in(sync_in), .din(din), .acc_out(acc_b), .acc_valid(val_b));

    function automatic int sv(input int d, input int i);
        return (i < 0) ? 0 : s_h[d][i];
    endfunction

    task automatic check_val(input string req, input int c, input int d,
                             input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d dut%0d actual %0d expected %0d", req, c, d, act, exp);
        end
    endtask

    task automatic check_cycle(input string req, input int c);
        for (int d = 0; d < 2; d++) begin
            longint a = (d == 0) ? acc_a : acc_b;
            bit v = (d == 0) ? val_a : val_b;
            if (tag_h[d][c])
                hold[d] = gain[d] * (-sv(d, c) + 9 * sv(d, c-2) + 16 * sv(d, c-3)
                                     + 9 * sv(d, c-4) - sv(d, c-6));
            check_val(req, c, d, longint'(v), longint'(tag_h[d][c]));
            check_val(req, c, d, a, longint'(hold[d]));
        end
    endtask

    // dpat: 0 random, 1 full scale, 2 impulse; spat: 0 low, 1 toggle, 2 random, 3 one re-anchor
    task automatic run_case(input logic up_i, input logic dn_i, input int dpat,
                            input int spat, input int n, input string req);
        bit prev_sync = 0;
        bit prev_slot = 0;
        rst = 1'b1; up_n = up_i; dn_n = dn_i; sync_in = 1'b0; din = '0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check_val("R1", -1, 0, longint'(val_a), 0);
        check_val("R1", -1, 0, longint'(acc_a), 0);
        check_val("R1", -1, 1, longint'(val_b), 0);
        check_val("R1", -1, 1, longint'(acc_b), 0);
        hold[0] = 0; hold[1] = 0;
        for (int d = 0; d < 2; d++) begin
            bit interp = (!up_i && dn_i) || (d == 1 && !up_i && !dn_i);
            gain[d] = (d == 1 && !up_i && !dn_i) ? 2 : 1;
            for (int c = 0; c < n; c++) tag_h[d][c] = 1'b1;
            if (interp) gain[d] = gain[d];
        end
        for (int c = 0; c < n + 2; c++) begin
            @(negedge clk);
            if (c >= 2) check_cycle(req, c - 2);
            rst = 1'b0;
            if (c < n) begin
                int v;
                bit sy;
                bit slot;
                case (dpat)
                    0: v = int'($urandom_range(4095)) - 2048;
                    1: v = ((c / 3) % 2 == 1) ? 2047 : -2048;
                    default: v = (c == 1) ? 1000 : 0;
                endcase
                case (spat)
                    0: sy = 1'b0;
                    1: sy = (c % 2 == 0);
                    2: sy = bit'($urandom_range(1));
                    default: sy = (c == 10);
                endcase
                slot = (prev_sync && !sy) ? 1'b1 : !prev_slot;
                prev_sync = sy;
                prev_slot = slot;
                for (int d = 0; d < 2; d++) begin
                    bit interp = (!up_i && dn_i) || (d == 1 && !up_i && !dn_i);
                    bit decim  = up_i && !dn_i;
                    s_h[d][c]   = (interp && !slot) ? 0 : v;
                    tag_h[d][c] = decim ? slot : 1'b1;
                end
                din = DW'(v);
                sync_in = sy;
            end else begin
                din = '0;
                sync_in = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        // R3 R9: equal rate, random data, R2 decode of both-high
        run_case(1'b1, 1'b1, 0, 0, 40, "R3");
        // R7: sync ignored in equal rate
        run_case(1'b1, 1'b1, 0, 2, 40, "R7");
        // R4 R6: interpolation impulse, free-running phase
        run_case(1'b0, 1'b1, 2, 0, 24, "R4");
        // R4 R6: interpolation random with mid-stream re-anchor
        run_case(1'b0, 1'b1, 0, 3, 40, "R6");
        // R5 R6: decimation with sync toggling at half rate
        run_case(1'b1, 1'b0, 0, 1, 40, "R5");
        // R5 R9: decimation full scale with re-anchor
        run_case(1'b1, 1'b0, 1, 3, 40, "R9");
        // R8 R2: both low -> equal (dut0) vs doubled interpolation (dut1)
        run_case(1'b0, 1'b0, 0, 0, 40, "R8");
        // R8 R9: doubled interpolation at full scale, toggling sync
        run_case(1'b0, 1'b0, 1, 1, 40, "R9");
        // R2: decimation impulse
        run_case(1'b1, 1'b0, 2, 0, 24, "R2");
        done = 1;
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end

endmodule